// File: doc/BRIEF.md
# Palette Converter Host Register Port

This block is the host-facing control logic of a true-color palette video converter. A microprocessor reaches it through active-low write and read strobes, a two-bit select and a data bus `DATA_W` bits wide (10 by default). The select picks one of four targets: the address pointer, the palette data port, the indirect control-register port, or the mode register. Control registers (an 8-bit pixel mask and three 8-bit command registers) are reached through the address pointer. The palette (256 locations of red, green and blue components, each `DATA_W` bits) is reached the same way and is accessed in red, green, blue order with automatic advance of the location.

The host strobes are asynchronous to the internal clock. Each one passes through a two-flop synchroniser, and the register update happens once, on the rising edge of the synchronised strobe. Holding a strobe low longer therefore does not repeat an access. The host must keep select and data stable while a strobe is low and for a few clocks after.

Two internal one-shot pulses are not driven by a reset pin. They are triggered by bit patterns written to the mode register over consecutive mode writes. Bit 0 going 1, 0, 1 requests a pipeline reset. Bit 5 going 0, 1, 0 requests a load-timing resynchronisation.

Top module: `palette_host_if`

## Requirements
- R1: After reset the pointer, the mode register, the pixel mask and the command registers read 00h, `hostDout` is 0 and neither pulse output is high.
- R2: Each low period of `hostWrN` or `hostRdN` performs exactly one access, however long the strobe is held.
- R3: Select code 0 writes and reads the 8-bit address pointer. Select code 3 writes and reads the 8-bit mode register.
- R4: With select code 2, pointer values 04h, 05h, 06h and 07h address the pixel mask and command registers 1, 2 and 3. A read returns exactly the low 8 bits last written, zero-extended.
- R5: With select code 2 and any other pointer value, a write changes no register and a read returns 0.
- R6: Select code 1 writes palette components in the order red, green, blue at the location held in the pointer. The pointer advances by one after the blue access and wraps from FFh to 00h.
- R7: Palette reads with select code 1 step through red, green and blue the same way and return the full `DATA_W`-bit value stored.
- R8: Writing the pointer returns the component phase to red.
- R9: When bit 0 of three consecutive mode writes is 1, then 0, then 1, `pipeResetPulse` is high for exactly one clock.
- R10: When bit 5 of three consecutive mode writes is 0, then 1, then 0, `loadResyncPulse` is high for exactly one clock.
- R11: A write to any target other than the mode register restarts both pattern detectors. After a pulse, the detector that fired needs three fresh mode writes before it can fire again.
- R12: `hostDout` changes only after a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrN | input | 1 | Asynchronous write strobe, active low |
| hostRdN | input | 1 | Asynchronous read strobe, active low |
| hostSel | input | 2 | Target select: 0 pointer, 1 palette, 2 control register, 3 mode |
| hostDin | input | DATA_W | Host write data |
| hostDout | output | DATA_W | Read data, held until the next read |
| pipeResetPulse | output | 1 | One-clock pipeline reset request |
| loadResyncPulse | output | 1 | One-clock load-timing resync request |

## Verification
The assertions check several properties on every cycle. Each pulse lasts one clock. A pulse appears only in the clock after a mode-register write event. No two host events are decoded in the same clock. The read data holds between read events. Register contents, palette ordering, pointer wrap, phase restart and pattern-restart behaviour can only be shown by the bench's scenarios. These include a full sweep that writes and reads all 768 palette components with values computed arithmetically.

// File: rtl/palette_host_pkg.sv
package palette_host_pkg;
  typedef enum logic [1:0] {SEL_PTR = 2'd0, SEL_PAL = 2'd1, SEL_CTRL = 2'd2, SEL_MODE = 2'd3} hostSel_t;
  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  typedef struct packed {
    logic     wrPtr;
    logic     wrMode;
    logic     wrCtrl;
    logic     wrPal;
    logic     rdAny;
    hostSel_t rdSel;
  } hostStb_t;

  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] IDX_MASK = 8'h04;
  localparam logic [REG_W-1:0] IDX_CMD1 = 8'h05;
  localparam logic [REG_W-1:0] IDX_CMD3 = 8'h07;
endpackage

// File: rtl/palette_toggle_detect.sv
module palette_toggle_detect #(
  parameter logic [2:0] PATTERN = 3'b101
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeWr,
  input  logic otherWr,
  input  logic bitVal,
  output logic pulse
);
  logic [2:0] hist;
  logic [1:0] seen;
  logic [2:0] nextHist;
  logic [1:0] nextSeen;

  always_comb begin
    nextHist = {hist[1:0], bitVal};
    nextSeen = (seen == 2'd3) ? 2'd3 : seen + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist  <= '0;
      seen  <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (modeWr) begin
        if (nextSeen == 2'd3 && nextHist == PATTERN) begin
          pulse <= 1'b1;
          seen  <= '0;
          hist  <= '0;
        end else begin
          hist <= nextHist;
          seen <= nextSeen;
        end
      end else if (otherWr) begin
        seen <= '0;
      end
    end
  end
endmodule

// File: rtl/palette_host_ctrl.sv
module palette_host_ctrl
  import palette_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostWrN,
  input  logic     hostRdN,
  input  logic [1:0] hostSel,
  input  logic     modeBit0,
  input  logic     modeBit5,
  output hostStb_t stb,
  output logic     pipeResetPulse,
  output logic     loadResyncPulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] wrChain;
  logic [CHAIN-1:0] rdChain;
  logic wrEvt;
  logic rdEvt;
  logic otherWr;
  hostSel_t sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrChain <= '0;
      rdChain <= '0;
    end else begin
      wrChain <= {wrChain[CHAIN-2:0], ~hostWrN};
      rdChain <= {rdChain[CHAIN-2:0], ~hostRdN};
    end
  end

  assign wrEvt = wrChain[CHAIN-2] & ~wrChain[CHAIN-1];
  assign rdEvt = rdChain[CHAIN-2] & ~rdChain[CHAIN-1];
  assign sel   = hostSel_t'(hostSel);

  always_comb begin
    stb.wrPtr  = wrEvt && sel == SEL_PTR;
    stb.wrPal  = wrEvt && sel == SEL_PAL;
    stb.wrCtrl = wrEvt && sel == SEL_CTRL;
    stb.wrMode = wrEvt && sel == SEL_MODE;
    stb.rdAny  = rdEvt && !wrEvt;
    stb.rdSel  = sel;
  end

  assign otherWr = wrEvt && sel != SEL_MODE;

  palette_toggle_detect #(.PATTERN(3'b101)) u_pipeDet (
    .clk(clk), .rstN(rstN), .modeWr(stb.wrMode), .otherWr(otherWr),
    .bitVal(modeBit0), .pulse(pipeResetPulse));

  palette_toggle_detect #(.PATTERN(3'b010)) u_syncDet (
    .clk(clk), .rstN(rstN), .modeWr(stb.wrMode), .otherWr(otherWr),
    .bitVal(modeBit5), .pulse(loadResyncPulse));
endmodule

// File: rtl/palette_host_datapath.sv
module palette_host_datapath
  import palette_host_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int PAL_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              modeBit0,
  output logic              modeBit5
);
  localparam int PAL_AW = $clog2(PAL_DEPTH);
  localparam int NUM_CMD = 3;

  logic [REG_W-1:0]  ptr;
  logic [REG_W-1:0]  modeReg;
  logic [REG_W-1:0]  pixMask;
  logic [REG_W-1:0]  cmdReg [NUM_CMD];
  phase_t            phase;
  logic [DATA_W-1:0] palMem [PAL_DEPTH][3];
  logic [PAL_AW-1:0] palIdx;
  logic              palStep;
  logic [REG_W-1:0]  ctrlRead;

  assign palIdx   = ptr[PAL_AW-1:0];
  assign palStep  = stb.wrPal || (stb.rdAny && stb.rdSel == SEL_PAL);
  assign modeBit0 = din[0];
  assign modeBit5 = din[5];

  always_comb begin
    ctrlRead = '0;
    if (ptr == IDX_MASK) ctrlRead = pixMask;
    for (int k = 0; k < NUM_CMD; k++)
      if (ptr == IDX_CMD1 + REG_W'(k)) ctrlRead = cmdReg[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      modeReg <= '0;
      pixMask <= '0;
      phase   <= PH_RED;
      dout    <= '0;
      for (int k = 0; k < NUM_CMD; k++) cmdReg[k] <= '0;
    end else begin
      if (stb.wrPtr) begin
        ptr   <= din[REG_W-1:0];
        phase <= PH_RED;
      end else if (palStep) begin
        if (phase == PH_BLU) begin
          phase <= PH_RED;
          ptr   <= ptr + 1'b1;
        end else begin
          phase <= phase_t'(phase + 2'd1);
        end
      end
      if (stb.wrMode) modeReg <= din[REG_W-1:0];
      if (stb.wrCtrl) begin
        if (ptr == IDX_MASK) pixMask <= din[REG_W-1:0];
        for (int k = 0; k < NUM_CMD; k++)
          if (ptr == IDX_CMD1 + REG_W'(k)) cmdReg[k] <= din[REG_W-1:0];
      end
      if (stb.rdAny) begin
        case (stb.rdSel)
          SEL_PTR:  dout <= DATA_W'(ptr);
          SEL_PAL:  dout <= palMem[palIdx][phase];
          SEL_CTRL: dout <= DATA_W'(ctrlRead);
          default:  dout <= DATA_W'(modeReg);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrPal) palMem[palIdx][phase] <= din;
  end
endmodule

// File: rtl/palette_host_if.sv
module palette_host_if
  import palette_host_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int PAL_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              pipeResetPulse,
  output logic              loadResyncPulse
);
  hostStb_t stb;
  logic modeBit0;
  logic modeBit5;

  palette_host_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrN(hostWrN), .hostRdN(hostRdN),
    .hostSel(hostSel), .modeBit0(modeBit0), .modeBit5(modeBit5),
    .stb(stb), .pipeResetPulse(pipeResetPulse), .loadResyncPulse(loadResyncPulse));

  palette_host_datapath #(.DATA_W(DATA_W), .PAL_DEPTH(PAL_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .din(hostDin), .dout(hostDout),
    .modeBit0(modeBit0), .modeBit5(modeBit5));
endmodule

// File: rtl/palette_host_checker.sv
module palette_host_checker
  import palette_host_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input hostStb_t          stb,
  input logic [DATA_W-1:0] hostDout,
  input logic              pipeResetPulse,
  input logic              loadResyncPulse
);
  assert_pipe_one_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    pipeResetPulse |=> !pipeResetPulse);
  assert_resync_one_clock_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadResyncPulse |=> !loadResyncPulse);
  assert_pipe_after_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pipeResetPulse) |-> $past(stb.wrMode));
  assert_resync_after_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadResyncPulse) |-> $past(stb.wrMode));
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrPtr, stb.wrMode, stb.wrCtrl, stb.wrPal, stb.rdAny}));
  assert_dout_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdAny |=> $stable(hostDout));
endmodule

bind palette_host_if palette_host_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .hostDout(hostDout),
  .pipeResetPulse(pipeResetPulse), .loadResyncPulse(loadResyncPulse));

// File: tb/palette_host_if_bench.sv
module palette_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrN = 1'b1;
  logic hostRdN = 1'b1;
  logic [1:0] hostSel = 2'd0;
  logic [DATA_W-1:0] hostDin = '0;
  logic [DATA_W-1:0] hostDout;
  logic pipeResetPulse;
  logic loadResyncPulse;

  int checks = 0;
  int fails = 0;
  int pipeCnt = 0;
  int syncCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  palette_host_if #(.DATA_W(DATA_W), .PAL_DEPTH(256)) u_palette_host_if (
    .clk(clk), .rstN(rstN), .hostWrN(hostWrN), .hostRdN(hostRdN),
    .hostSel(hostSel), .hostDin(hostDin), .hostDout(hostDout),
    .pipeResetPulse(pipeResetPulse), .loadResyncPulse(loadResyncPulse));

  always @(posedge clk) begin
    if (rstN && pipeResetPulse) pipeCnt++;
    if (rstN && loadResyncPulse) syncCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input int data, input int hold = 4);
    @(negedge clk);
    hostSel = sel;
    hostDin = DATA_W'(data);
    @(negedge clk);
    hostWrN = 1'b0;
    repeat (hold) @(negedge clk);
    hostWrN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] sel, output int data);
    @(negedge clk);
    hostSel = sel;
    @(negedge clk);
    hostRdN = 1'b0;
    repeat (4) @(negedge clk);
    hostRdN = 1'b1;
    repeat (4) @(negedge clk);
    data = int'(hostDout);
  endtask

  function automatic int palVal(input int idx, input int comp);
    return (idx * 37 + comp * 311 + 11) % 1024;
  endfunction

  initial begin
    int rd;
    int p0;
    int s0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 dout", int'(hostDout), 0);
    check("R1 pulses", int'({pipeResetPulse, loadResyncPulse}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    hostRead(2'd0, rd); check("R1 ptr", rd, 0);
    hostRead(2'd3, rd); check("R1 mode", rd, 0);
    for (int a = 4; a < 8; a++) begin
      hostWrite(2'd0, a);
      hostRead(2'd2, rd); check("R1 ctrl reg", rd, 0);
    end

    // R3: pointer and mode readback
    hostWrite(2'd0, 8'hA5); hostRead(2'd0, rd); check("R3 ptr", rd, 8'hA5);
    hostWrite(2'd3, 8'h3C); hostRead(2'd3, rd); check("R3 mode", rd, 8'h3C);

    // R4: indirect registers, exact readback, 8-bit truncation
    for (int a = 4; a < 8; a++) begin
      hostWrite(2'd0, a);
      hostWrite(2'd2, 10'h300 | (a * 29 + 3));
      hostRead(2'd2, rd); check("R4 readback after write", rd, (a * 29 + 3) & 8'hFF);
    end
    for (int a = 4; a < 8; a++) begin
      hostWrite(2'd0, a);
      hostRead(2'd2, rd); check("R4 later readback", rd, (a * 29 + 3) & 8'hFF);
    end
    hostWrite(2'd0, 4); hostWrite(2'd2, 8'hFF);
    hostRead(2'd2, rd); check("R4 mask all ones", rd, 8'hFF);

    // R5: unmapped pointer values in control select
    hostWrite(2'd0, 8'h08); hostWrite(2'd2, 8'h55);
    hostRead(2'd2, rd); check("R5 unmapped read", rd, 0);
    hostWrite(2'd0, 8'h03); hostWrite(2'd2, 8'h66);
    hostRead(2'd2, rd); check("R5 unmapped read", rd, 0);
    for (int a = 5; a < 8; a++) begin
      hostWrite(2'd0, a);
      hostRead(2'd2, rd); check("R5 mapped untouched", rd, (a * 29 + 3) & 8'hFF);
    end

    // R6, R7: full palette sweep with wrap
    hostWrite(2'd0, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) hostWrite(2'd1, palVal(i, c));
    hostRead(2'd0, rd); check("R6 wrap to 00h", rd, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        hostRead(2'd1, rd); check("R7 palette read", rd, palVal(i, c));
      end
    hostRead(2'd0, rd); check("R7 read wrap", rd, 0);

    // R2: long write strobe counts once
    hostWrite(2'd0, 8'h10);
    hostWrite(2'd1, 10'h123, 40);
    hostWrite(2'd1, 10'h234);
    hostWrite(2'd1, 10'h345);
    hostRead(2'd0, rd); check("R2 one advance", rd, 8'h11);
    hostWrite(2'd0, 8'h10);
    hostRead(2'd1, rd); check("R2 red", rd, 10'h123);
    hostRead(2'd1, rd); check("R2 green", rd, 10'h234);

    // R8: pointer write restarts phase
    hostWrite(2'd0, 8'hFE);
    hostWrite(2'd1, 10'h0AA);
    hostWrite(2'd1, 10'h0BB);
    hostWrite(2'd0, 8'hFE);
    hostRead(2'd1, rd); check("R8 red after restart", rd, 10'h0AA);
    hostRead(2'd1, rd); check("R8 green", rd, 10'h0BB);
    hostRead(2'd1, rd); check("R8 blue untouched", rd, palVal(254, 2));

    // R9: pipeline reset pattern on bit 0
    hostWrite(2'd0, 0);
    p0 = pipeCnt; s0 = syncCnt;
    hostWrite(2'd3, 8'h01); hostWrite(2'd3, 8'h00);
    check("R9 no early pulse", pipeCnt - p0, 0);
    hostWrite(2'd3, 8'h01);
    check("R9 one pulse", pipeCnt - p0, 1);
    check("R10 no resync on bit0 pattern", syncCnt - s0, 0);
    hostWrite(2'd3, 8'h00); hostWrite(2'd3, 8'h01);
    check("R11 needs fresh writes", pipeCnt - p0, 1);

    // R10: resync pattern on bit 5
    hostWrite(2'd0, 0);
    p0 = pipeCnt; s0 = syncCnt;
    hostWrite(2'd3, 8'h00); hostWrite(2'd3, 8'h20); hostWrite(2'd3, 8'h00);
    check("R10 one resync", syncCnt - s0, 1);
    check("R9 no pipe on bit5 pattern", pipeCnt - p0, 0);

    // R11: interrupted patterns
    hostWrite(2'd0, 0);
    p0 = pipeCnt; s0 = syncCnt;
    hostWrite(2'd3, 8'h01); hostWrite(2'd3, 8'h00);
    hostWrite(2'd0, 8'h04);
    hostWrite(2'd3, 8'h01);
    check("R11 pointer write breaks", pipeCnt - p0, 0);
    hostWrite(2'd0, 0);
    hostWrite(2'd3, 8'h00); hostWrite(2'd3, 8'h20);
    hostWrite(2'd1, 10'h1);
    hostWrite(2'd3, 8'h00);
    check("R11 palette write breaks", syncCnt - s0, 0);

    // R9, R10: full init sequence
    hostWrite(2'd0, 0);
    p0 = pipeCnt; s0 = syncCnt;
    hostWrite(2'd3, 8'h0F); hostWrite(2'd3, 8'h0E); hostWrite(2'd3, 8'h0F);
    hostWrite(2'd3, 8'h2F); hostWrite(2'd3, 8'h0F);
    check("R9 init sequence", pipeCnt - p0, 1);
    check("R10 init sequence", syncCnt - s0, 1);

    // R12: writes leave read data untouched
    hostRead(2'd0, rd);
    hostWrite(2'd0, 8'h77); hostWrite(2'd3, 8'h12);
    check("R12 dout held", int'(hostDout), rd);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule